// File: doc/BRIEF.md
# Key-Ordered Insertion Queue

This block is a fixed-depth queue whose entries leave strictly from the head but arrive at a position chosen by a sort key. Each arrival brings a key, read as a departure time, and a payload. The arrival is placed behind every stored entry whose key is smaller or equal, and ahead of every stored entry whose key is larger. Entries already held keep their order with respect to one another, so the queue always presents the entry with the smallest key first.

A scheduler picks the key to get the discipline it wants. A finishing-time stamp gives weighted-fair service. A class number gives strict priority. A constant key gives a plain FIFO. Storage is a register array with one comparator per slot, so every insertion completes in one cycle. In the same cycle a pop can remove the head, and the insertion point is then worked out against the queue that remains after that removal.

Top module: `pifo_queue`

## Requirements
- R1: After reset the queue is empty: `count` is 0, `popValid` is 0 and `pushReady` is 1.
- R2: Entries leave through the pop port in nondecreasing key order, whatever order they arrived in.
- R3: An arrival whose key equals one or more stored keys is placed behind all of them. Entries with equal keys therefore leave in arrival order.
- R4: While `popValid` is 1, `popKey` and `popData` show the stored entry that is due next. They hold their value in any cycle with no accepted push and no accepted pop.
- R5: While `count` equals DEPTH, `pushReady` is 0. A push offered in that state is refused and changes neither the count nor the contents.
- R6: A pop requested while the queue is empty is ignored. `popValid` is 0 and `count` stays 0.
- R7: When a push and a pop are both accepted in one cycle, the old head leaves first. The arrival is then placed among the remaining entries, and `count` does not change. This holds even when the new key is smaller than the old head's key.
- R8: `count` reports the number of stored entries. It rises by one on an accepted push alone and falls by one on an accepted pop alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | An arrival is offered |
| pushReady | output | 1 | The queue can accept an arrival (not full) |
| pushKey | input | KEY_W | Sort key of the arrival |
| pushData | input | DATA_W | Payload of the arrival |
| popValid | output | 1 | A head entry is present |
| popReady | input | 1 | Consumer takes the head this cycle |
| popKey | output | KEY_W | Key of the head entry |
| popData | output | DATA_W | Payload of the head entry |
| count | output | CNT_W | Number of stored entries, 0 to DEPTH |

## Verification
The hardest case to reach from the ports is a cycle that accepts both a pop and a push. In that cycle the insertion point must be found against the shifted queue and not the stored one. The stimulus table builds a mixed queue first. It then issues combined cycles in which the new key lands before the old head, in the middle, and into a queue of one. Each following pop shows where the arrival ended up. The queue is also filled with keys in descending order so that every arrival goes to the head, a push is offered while the queue is full, and the queue is then drained to confirm that the refused arrival never got in.

// File: rtl/pifo_pkg.sv
package pifo_pkg;
  // Strobes from control to datapath: one accepted transfer per direction
  typedef struct packed {
    logic push;
    logic pop;
  } pifo_strobe_t;
endpackage

// File: rtl/pifo_ctrl.sv
module pifo_ctrl
  import pifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pushValid,
  input  logic             popReady,
  output logic             pushReady,
  output logic             popValid,
  output logic [CNT_W-1:0] count,
  output pifo_strobe_t     strobe
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] occ;

  assign pushReady = (occ != FULL_CNT);
  assign popValid  = (occ != '0);
  assign strobe.push = pushValid && pushReady;
  assign strobe.pop  = popValid && popReady;
  assign count = occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/pifo_store.sv
module pifo_store
  import pifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int KEY_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pifo_strobe_t      strobe,
  input  logic [KEY_W-1:0]  inKey,
  input  logic [DATA_W-1:0] inData,
  output logic [KEY_W-1:0]  headKey,
  output logic [DATA_W-1:0] headData
);
  logic [KEY_W-1:0]  slotKey  [DEPTH];
  logic [DATA_W-1:0] slotData [DEPTH];
  logic [DEPTH-1:0]  slotVld;

  // Contents as seen after an accepted pop has removed the head
  logic [KEY_W-1:0]  viewKey  [DEPTH];
  logic [DATA_W-1:0] viewData [DEPTH];
  logic [DEPTH-1:0]  viewVld;
  // behind[i]: the arrival sorts behind view slot i (key smaller or equal)
  logic [DEPTH-1:0]  behind;
  logic [DEPTH-1:0]  prevBehind;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_slot
      if (i < DEPTH - 1) begin : g_mid
        assign viewKey[i]  = strobe.pop ? slotKey[i+1]  : slotKey[i];
        assign viewData[i] = strobe.pop ? slotData[i+1] : slotData[i];
        assign viewVld[i]  = strobe.pop ? slotVld[i+1]  : slotVld[i];
      end else begin : g_last
        assign viewKey[i]  = strobe.pop ? '0   : slotKey[i];
        assign viewData[i] = strobe.pop ? '0   : slotData[i];
        assign viewVld[i]  = strobe.pop ? 1'b0 : slotVld[i];
      end

      assign behind[i] = viewVld[i] && (viewKey[i] <= inKey);

      if (i == 0) begin : g_head
        assign prevBehind[i] = 1'b1;
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            slotKey[i]  <= '0;
            slotData[i] <= '0;
            slotVld[i]  <= 1'b0;
          end else if (strobe.push && !behind[i]) begin
            slotKey[i]  <= inKey;
            slotData[i] <= inData;
            slotVld[i]  <= 1'b1;
          end else begin
            slotKey[i]  <= viewKey[i];
            slotData[i] <= viewData[i];
            slotVld[i]  <= viewVld[i];
          end
        end
      end else begin : g_body
        assign prevBehind[i] = behind[i-1];
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            slotKey[i]  <= '0;
            slotData[i] <= '0;
            slotVld[i]  <= 1'b0;
          end else if (strobe.push && !behind[i] && prevBehind[i]) begin
            slotKey[i]  <= inKey;
            slotData[i] <= inData;
            slotVld[i]  <= 1'b1;
          end else if (strobe.push && !behind[i]) begin
            slotKey[i]  <= viewKey[i-1];
            slotData[i] <= viewData[i-1];
            slotVld[i]  <= viewVld[i-1];
          end else begin
            slotKey[i]  <= viewKey[i];
            slotData[i] <= viewData[i];
            slotVld[i]  <= viewVld[i];
          end
        end
      end
    end
  endgenerate

  assign headKey  = slotKey[0];
  assign headData = slotData[0];
endmodule

// File: rtl/pifo_queue.sv
module pifo_queue
  import pifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int KEY_W  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pushValid,
  output logic              pushReady,
  input  logic [KEY_W-1:0]  pushKey,
  input  logic [DATA_W-1:0] pushData,
  output logic              popValid,
  input  logic              popReady,
  output logic [KEY_W-1:0]  popKey,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  count
);
  pifo_strobe_t strobe;

  pifo_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .popReady(popReady),
    .pushReady(pushReady), .popValid(popValid), .count(count), .strobe(strobe)
  );

  pifo_store #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) store (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inKey(pushKey),
    .inData(pushData), .headKey(popKey), .headData(popData)
  );
endmodule

// File: rtl/pifo_queue_chk.sv
module pifo_queue_chk #(
  parameter int DEPTH  = 16,
  parameter int KEY_W  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pushValid,
  input logic              pushReady,
  input logic              popValid,
  input logic              popReady,
  input logic [KEY_W-1:0]  popKey,
  input logic [DATA_W-1:0] popData,
  input logic [CNT_W-1:0]  count
);
  wire pushAcc = pushValid && pushReady;
  wire popAcc  = popValid && popReady;

  // R5
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !pushReady);

  // R6
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> (count == '0 || $past(pushValid)));

  // R7
  swap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pushAcc && popAcc) |=> $stable(count));

  // R8
  grow_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pushAcc && !popAcc) |=> (count == $past(count) + 1'b1));

  // R8
  shrink_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (popAcc && !pushAcc) |=> (count == $past(count) - 1'b1));

  // R4
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (popValid && !pushAcc && !popAcc) |=> ($stable(popKey) && $stable(popData)));

  // R2
  order_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (popAcc && !pushAcc && count > 1) |=> (popKey >= $past(popKey)));

  // R6
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !popValid);
endmodule

bind pifo_queue pifo_queue_chk #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .pushReady(pushReady),
  .popValid(popValid), .popReady(popReady), .popKey(popKey),
  .popData(popData), .count(count)
);

// File: tb/pifo_queue_test.sv
module pifo_queue_test;
  localparam int DEPTH = 16;
  localparam int KEY_W = 16;
  localparam int DATA_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pushValid = 1'b0, popReady = 1'b0;
  logic [KEY_W-1:0] pushKey = '0;
  logic [DATA_W-1:0] pushData = '0;
  logic pushReady, popValid;
  logic [KEY_W-1:0] popKey;
  logic [DATA_W-1:0] popData;
  logic [CNT_W-1:0] count;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pifo_queue #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .pushReady(pushReady),
    .pushKey(pushKey), .pushData(pushData), .popValid(popValid),
    .popReady(popReady), .popKey(popKey), .popData(popData), .count(count)
  );

  typedef struct packed {
    logic        push;
    logic [15:0] key;
    logic [7:0]  data;
    logic        pop;
    logic [15:0] eKey;
    logic [7:0]  eData;
    logic [4:0]  eCnt;
  } vec_t;

  // Mixed arrivals, an equal key, and combined push+pop cycles
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'd50, 8'hA1, 1'b0, 16'd0,  8'h00, 5'd1},
    '{1'b1, 16'd20, 8'hA2, 1'b0, 16'd0,  8'h00, 5'd2},
    '{1'b1, 16'd80, 8'hA3, 1'b0, 16'd0,  8'h00, 5'd3},
    '{1'b1, 16'd50, 8'hA4, 1'b0, 16'd0,  8'h00, 5'd4},
    '{1'b1, 16'd10, 8'hA5, 1'b1, 16'd20, 8'hA2, 5'd4},
    '{1'b0, 16'd0,  8'h00, 1'b1, 16'd10, 8'hA5, 5'd3},
    '{1'b1, 16'd60, 8'hA6, 1'b1, 16'd50, 8'hA1, 5'd3},
    '{1'b0, 16'd0,  8'h00, 1'b1, 16'd50, 8'hA4, 5'd2},
    '{1'b1, 16'd70, 8'hA7, 1'b0, 16'd0,  8'h00, 5'd3},
    '{1'b0, 16'd0,  8'h00, 1'b1, 16'd60, 8'hA6, 5'd2},
    '{1'b0, 16'd0,  8'h00, 1'b1, 16'd70, 8'hA7, 5'd1},
    '{1'b0, 16'd0,  8'h00, 1'b1, 16'd80, 8'hA3, 5'd0}
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check head before the edge, count after it
  task automatic step(input bit doPush, input int k, input int d, input bit doPop,
                      input bit chkHead, input int eK, input int eD, input int eC,
                      input string req);
    @(negedge clk);
    pushValid = doPush; pushKey = KEY_W'(k); pushData = DATA_W'(d); popReady = doPop;
    #1;
    if (chkHead) begin
      check({req, " popValid"}, popValid, 1);
      check({req, " popKey"}, popKey, eK);
      check({req, " popData"}, popData, eD);
    end
    @(posedge clk); #1;
    pushValid = 1'b0; popReady = 1'b0;
    check({req, " count"}, count, eC);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 popValid", popValid, 0);
    check("R1 pushReady", pushReady, 1);

    // R2 R3 R7 R8 table walk
    for (int v = 0; v < NV; v++)
      step(VEC[v].push, VEC[v].key, VEC[v].data, VEC[v].pop, VEC[v].pop,
           VEC[v].eKey, VEC[v].eData, VEC[v].eCnt, "R2/R3/R7 vec");

    // R6 pop on empty is ignored
    step(1'b0, 0, 0, 1'b1, 1'b0, 0, 0, 0, "R6 empty pop");
    check("R6 popValid", popValid, 0);

    // R5 fill with descending keys so each arrival becomes the head (R4)
    for (int n = 0; n < DEPTH; n++) begin
      step(1'b1, DEPTH - n, 8'h40 + n, 1'b0, 1'b0, 0, 0, n + 1, "R8 fill");
      check("R4 head key", popKey, DEPTH - n);
    end
    check("R5 pushReady", pushReady, 0);
    step(1'b1, 0, 8'hEE, 1'b0, 1'b0, 0, 0, DEPTH, "R5 refused push");
    for (int n = 0; n < DEPTH; n++)
      step(1'b0, 0, 0, 1'b1, 1'b1, n + 1, 8'h40 + DEPTH - 1 - n, DEPTH - 1 - n, "R5 drain");

    // R3 burst of equal keys leaves in arrival order
    for (int n = 0; n < 5; n++)
      step(1'b1, 7, n, 1'b0, 1'b0, 0, 0, n + 1, "R3 burst");
    for (int n = 0; n < 5; n++)
      step(1'b0, 0, 0, 1'b1, 1'b1, 7, n, 4 - n, "R3 drain");

    // R7 combined cycle with a single stored entry
    step(1'b1, 9, 8'h11, 1'b0, 1'b0, 0, 0, 1, "R7 seed");
    step(1'b1, 3, 8'h22, 1'b1, 1'b1, 9, 8'h11, 1, "R7 swap");
    step(1'b0, 0, 0, 1'b1, 1'b1, 3, 8'h22, 0, "R7 after");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule